// File: doc/BRIEF.md
# Three-Wire Serial Control Bus Slave Front End

This block is the slave side of a slow three-line control bus. A master drives a frame line and a bit clock, and both sides share one open-drain data line. While the frame line is low, the master clocks in an 8-bit device address, least significant bit first. The rising edge of the frame line ends the address phase. The slave then compares the address with its three codes: load-address, read and program.

On a match the slave takes part in the data phase:
- For a load-address or program code, it shifts in a 16-bit word.
- For a read code, it pulls the data line low for each zero bit of a parallel read byte. The master may clock 8 or 16 bits for a read.

The master closes the frame with a short low pulse on the frame line. The received word and the function code are committed only at that pulse, and a one-cycle completion strobe marks the commit. A static option input selects one of two address sets, so two slaves can share the bus.

The three bus lines are sampled by a fast system clock through two-stage synchronizers. All bus events are taken from the synchronized copies.

Top module: `serial_ctl_slave`

## Requirements
- R1: While `rst_n` is low, `func_code`, `rx_word` and `done` read 0 and `data_pull` is 0. Taking `rst_n` low in the middle of a frame abandons that frame, so no `done` follows for it.
- R2: Address bits are sampled on rising `bus_clk` edges while `bus_ident` is low, least significant bit first. The address is compared on the rising edge of `bus_ident`. With `opt_hi`=0 the codes are 128 (load), 129 (read) and 131 (program); with `opt_hi`=1 they are 132, 133 and 135.
- R3: The rest of a frame is ignored, with no `done` and `data_pull` held at 0, when either of these holds:
  - the address matches no code;
  - not exactly 8 address clocks were given.
- R4: `func_code` uses the encoding 1 = load, 2 = read and 3 = program. It changes only in the cycle `done` is high.
- R5: For load and program, data bit i (counted from 0 in clock order) lands in `rx_word[i]`. `rx_word` changes only with `done`.
- R6: `done` is a one-cycle pulse raised by the falling edge of `bus_ident` that ends a matched data phase. It is raised only if the data phase had exactly 16 clocks, or exactly 8 or 16 clocks for a read. Otherwise the outputs hold.
- R7: `data_pull` is 1 only during a read data phase, only for data bit indices 0 to 7, and only when the matching bit of `rd_byte` is 0. The slave takes `rd_byte` at the rising `bus_ident` edge that ends the address phase.
- R8: The slave also records a read from the data line. An 8-bit read commits `rx_word` = {8'h00, line bits}. A 16-bit read commits the line bits, so the released upper byte reads 8'hFF.
- R9: Each bus line passes through two synchronizing registers. A frame-line change made between system clock edges j-1 and j takes effect on the registered outputs at edge j+2.
- R10: After a commit, or after an ignored frame, the slave waits for `bus_ident` to return high. The next frame is then recognized normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts a frame |
| opt_hi | input | 1 | Address set select (0: 128/129/131, 1: 132/133/135) |
| bus_ident | input | 1 | Frame line: low for address, high for data, low pulse to end |
| bus_clk | input | 1 | Bus bit clock, sampled on its rising edge |
| bus_data | input | 1 | Resolved level of the open-drain data line |
| rd_byte | input | 8 | Byte supplied for read frames |
| data_pull | output | 1 | 1 = pull the data line low |
| func_code | output | 2 | Committed function: 0 none, 1 load, 2 read, 3 program |
| rx_word | output | 16 | Committed data word |
| done | output | 1 | One-cycle commit strobe |

## Verification
The bench runs load, program, 8-bit read and 16-bit read frames under both option settings. It uses read bytes with mixed zeros and ones, which shows whether the pull-down follows the bit index and byte order. Frames with an unmatched address, a seven-clock address, a twelve-clock data phase and a seventeen-clock data phase show that the slave commits only exactly framed transfers. A reset in the middle of a read shows that the abort releases the line. A cycle-by-cycle model of the synchronizer delay pins down the three-edge latency from the end pulse to the strobe.

// File: rtl/serial_ctl_slave.sv
module serial_ctl_slave #(
  parameter logic [7:0] SET_LO   = 8'd128,
  parameter logic [7:0] SET_HI   = 8'd132,
  parameter int         WORD_W   = 16,
  parameter int         BYTE_W   = 8,
  parameter int         CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opt_hi,
  input  logic              bus_ident,
  input  logic              bus_clk,
  input  logic              bus_data,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              data_pull,
  output logic [1:0]        func_code,
  output logic [WORD_W-1:0] rx_word,
  output logic              done
);

  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_DATA = 3'd2,
                         S_SKIP = 3'd3, S_ENDP = 3'd4;
  localparam logic [1:0] F_NONE = 2'd0, F_LOAD = 2'd1, F_READ = 2'd2, F_PROG = 2'd3;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] N_BYTE   = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] N_WORD   = CNT_W'(WORD_W);
  localparam int               AIX_W    = $clog2(BYTE_W);
  localparam int               WIX_W    = $clog2(WORD_W);

  logic [1:0] id_sy, ck_sy, dt_sy;
  logic       id_pv, ck_pv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_sy <= 2'b11;
      ck_sy <= 2'b11;
      dt_sy <= 2'b11;
      id_pv <= 1'b1;
      ck_pv <= 1'b1;
    end else begin
      id_sy <= {id_sy[0], bus_ident};
      ck_sy <= {ck_sy[0], bus_clk};
      dt_sy <= {dt_sy[0], bus_data};
      id_pv <= id_sy[1];
      ck_pv <= ck_sy[1];
    end
  end

  wire id_rise = id_sy[1] & ~id_pv;
  wire id_fall = ~id_sy[1] & id_pv;
  wire ck_rise = ck_sy[1] & ~ck_pv;
  wire din     = dt_sy[1];

  logic [2:0]        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] addr;
  logic [1:0]        pend;
  logic [WORD_W-1:0] shreg;
  logic [BYTE_W-1:0] rdq;
  logic [1:0]        hit;

  wire [7:0] base = opt_hi ? SET_HI : SET_LO;

  always_comb begin
    hit = F_NONE;
    if (addr == base)              hit = F_LOAD;
    else if (addr == base + 8'd1)  hit = F_READ;
    else if (addr == base + 8'd3)  hit = F_PROG;
  end

  wire [CNT_W-1:0] cnt_nx   = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  wire             len_ok   = (cnt == N_WORD) || (pend == F_READ && cnt == N_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      addr      <= '0;
      pend      <= F_NONE;
      shreg     <= '0;
      rdq       <= '0;
      func_code <= F_NONE;
      rx_word   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (id_fall) begin
          state <= S_ADDR;
          cnt   <= '0;
          addr  <= '0;
        end
        S_ADDR: begin
          if (id_rise) begin
            if (cnt == N_BYTE && hit != F_NONE) begin
              state <= S_DATA;
              pend  <= hit;
              cnt   <= '0;
              shreg <= '0;
              if (hit == F_READ) rdq <= rd_byte;
            end else begin
              state <= S_SKIP;
            end
          end else if (ck_rise) begin
            if (cnt < N_BYTE) addr[cnt[AIX_W-1:0]] <= din;
            cnt <= cnt_nx;
          end
        end
        S_DATA: begin
          if (id_fall) begin
            if (len_ok) begin
              done      <= 1'b1;
              func_code <= pend;
              rx_word   <= shreg;
            end
            state <= S_ENDP;
          end else if (ck_rise) begin
            if (cnt < N_WORD) shreg[cnt[WIX_W-1:0]] <= din;
            cnt <= cnt_nx;
          end
        end
        S_SKIP: if (id_fall) state <= S_ENDP;
        S_ENDP: if (id_rise) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign data_pull = (state == S_DATA) && (pend == F_READ) && (cnt < N_BYTE)
                     && !rdq[cnt[AIX_W-1:0]];

endmodule

// File: rtl/serial_ctl_slave_chk.sv
module serial_ctl_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  st,
  input logic        data_pull,
  input logic        done,
  input logic [1:0]  func_code,
  input logic [15:0] rx_word
);
  localparam logic [2:0] S_SKIP = 3'd3, S_ENDP = 3'd4;

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> st == S_ENDP);

  a_r4_func_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(func_code));

  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_word));

  a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SKIP |-> !data_pull);

  a_r7_no_pull_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_ENDP |-> !data_pull);
endmodule

bind serial_ctl_slave serial_ctl_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .data_pull(data_pull),
  .done(done), .func_code(func_code), .rx_word(rx_word)
);

// File: tb/serial_ctl_slave_bench.sv
module serial_ctl_slave_bench;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0, opt_hi = 0, m_id = 1, m_ck = 1, m_d = 1;
  logic [7:0] rd_byte = 8'h00;
  logic data_pull, done;
  logic [1:0] func_code;
  logic [15:0] rx_word;
  wire line = m_d & ~data_pull;

  serial_ctl_slave u_serial_ctl_slave (
    .clk(clk), .rst_n(rst_n), .opt_hi(opt_hi), .bus_ident(m_id), .bus_clk(m_ck),
    .bus_data(line), .rd_byte(rd_byte), .data_pull(data_pull),
    .func_code(func_code), .rx_word(rx_word), .done(done));

  int checks = 0, errors = 0, done_cnt = 0, pull_cnt = 0;
  localparam int H = 6;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic hi[3], hc[3], hd[3];
  int m_state = 0, m_cnt = 0, m_pend = 0;
  logic [7:0] m_addr, m_rdq;
  logic [15:0] m_sh;
  int e_func = 0; logic [15:0] e_rx = 0; bit e_done = 0, e_pull = 0;
  bit started = 0;

  function automatic int code_of(input logic [7:0] a, input logic o);
    int b = o ? 132 : 128;
    if (a == b) return 1;
    if (a == b + 1) return 2;
    if (a == b + 3) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit fid, rid, rck; logic dv; int cd;
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin hi[k] = 1; hc[k] = 1; hd[k] = 1; end
      m_state = 0; m_cnt = 0; m_pend = 0; m_addr = 0; m_rdq = 0; m_sh = 0;
      e_func = 0; e_rx = 0; e_done = 0;
    end else begin
      fid = !hi[1] && hi[2]; rid = hi[1] && !hi[2]; rck = hc[1] && !hc[2]; dv = hd[1];
      e_done = 0;
      case (m_state)
        0: if (fid) begin m_state = 1; m_cnt = 0; m_addr = 0; end
        1: if (rid) begin
             cd = code_of(m_addr, opt_hi);
             if (m_cnt == 8 && cd != 0) begin
               m_state = 2; m_pend = cd; m_cnt = 0; m_sh = 0;
               if (cd == 2) m_rdq = rd_byte;
             end else m_state = 3;
           end else if (rck) begin
             if (m_cnt < 8) m_addr[m_cnt] = dv;
             if (m_cnt < 31) m_cnt++;
           end
        2: if (fid) begin
             if (m_cnt == 16 || (m_pend == 2 && m_cnt == 8)) begin
               e_done = 1; e_func = m_pend; e_rx = m_sh;
             end
             m_state = 4;
           end else if (rck) begin
             if (m_cnt < 16) m_sh[m_cnt] = dv;
             if (m_cnt < 31) m_cnt++;
           end
        3: if (fid) m_state = 4;
        4: if (rid) m_state = 0;
        default: m_state = 0;
      endcase
      hi[2] = hi[1]; hi[1] = hi[0]; hi[0] = m_id;
      hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = m_ck;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = line;
    end
    e_pull = (m_state == 2 && m_pend == 2 && m_cnt < 8 && !m_rdq[m_cnt]);
    #2;
    if (started) begin
      chk(done == e_done, "R6 done vs model", done, e_done);
      chk(func_code == e_func[1:0], "R4 func_code vs model", func_code, e_func);
      chk(rx_word == e_rx, "R5 rx_word vs model", rx_word, e_rx);
      chk(data_pull == e_pull, "R7 data_pull vs model", data_pull, e_pull);
      if (done) done_cnt++;
      if (data_pull) pull_cnt++;
    end
  end

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  // na: address clocks, nd: data clocks, ok: commit expected (R9 latency checked)
  task automatic xfer(input logic [7:0] a, input int na, input int nd,
                      input logic [15:0] w, input bit ok);
    @(negedge clk); m_id = 0; wait_h(H);
    for (int i = 0; i < na; i++) begin
      m_ck = 0; m_d = a[i % 8]; wait_h(H); m_ck = 1; wait_h(H);
    end
    m_d = 1; m_id = 1; wait_h(H);
    for (int i = 0; i < nd; i++) begin
      m_ck = 0; m_d = w[i % 16]; wait_h(H); m_ck = 1; wait_h(H);
    end
    m_d = 1; wait_h(H);
    m_id = 0;
    repeat (2) @(posedge clk);
    #3 chk(done == 0, "R9 no strobe before third edge", done, 0);
    @(posedge clk);
    #3 chk(done == ok, "R9 strobe on third edge", done, ok);
    wait_h(H); m_id = 1; wait_h(2 * H);
  endtask

  int dc;
  initial begin
    wait_h(3);
    started = 1;
    #1 chk(func_code == 0 && rx_word == 0 && done == 0 && data_pull == 0,
           "R1 reset state", {func_code, rx_word}, 0);
    @(negedge clk); rst_n = 1; wait_h(4);

    xfer(8'd128, 8, 16, 16'h01A5, 1);
    chk(func_code == 1, "R2 R4 load code 128", func_code, 1);
    chk(rx_word == 16'h01A5, "R5 load word", rx_word, 16'h01A5);

    xfer(8'd131, 8, 16, 16'h00FF, 1);
    chk(func_code == 3, "R4 program code 131", func_code, 3);
    chk(rx_word == 16'h00FF, "R5 program word", rx_word, 16'h00FF);

    rd_byte = 8'h5A; dc = pull_cnt;
    xfer(8'd129, 8, 16, 16'hFFFF, 1);
    chk(func_code == 2, "R4 read code 129", func_code, 2);
    chk(rx_word == 16'hFF5A, "R8 16-bit read word", rx_word, 16'hFF5A);
    chk(pull_cnt > dc, "R7 line pulled during read", pull_cnt - dc, 1);

    rd_byte = 8'h3C;
    xfer(8'd129, 8, 8, 16'hFFFF, 1);
    chk(rx_word == 16'h003C, "R8 8-bit read word", rx_word, 16'h003C);

    dc = done_cnt; rd_byte = 8'h00;
    xfer(8'd130, 8, 16, 16'h1111, 0);
    chk(done_cnt == dc, "R3 unmatched no strobe", done_cnt - dc, 0);
    chk(rx_word == 16'h003C, "R3 unmatched holds word", rx_word, 16'h003C);

    xfer(8'd129, 7, 8, 16'hFFFF, 0);
    chk(rx_word == 16'h003C && func_code == 2, "R3 seven address clocks ignored", rx_word, 16'h003C);

    xfer(8'd128, 8, 12, 16'h0ABC, 0);
    chk(rx_word == 16'h003C, "R6 twelve data clocks no commit", rx_word, 16'h003C);
    xfer(8'd128, 8, 17, 16'h0ABC, 0);
    chk(func_code == 2, "R6 seventeen data clocks no commit", func_code, 2);

    xfer(8'd131, 8, 16, 16'h8001, 1);
    chk(rx_word == 16'h8001, "R10 frame after ignored frames", rx_word, 16'h8001);

    opt_hi = 1;
    xfer(8'd128, 8, 16, 16'h2222, 0);
    chk(rx_word == 16'h8001, "R2 opt high ignores 128", rx_word, 16'h8001);
    xfer(8'd132, 8, 16, 16'h1234, 1);
    chk(func_code == 1 && rx_word == 16'h1234, "R2 opt high load 132", rx_word, 16'h1234);
    xfer(8'd135, 8, 16, 16'hBEEF, 1);
    chk(func_code == 3 && rx_word == 16'hBEEF, "R2 opt high program 135", rx_word, 16'hBEEF);
    rd_byte = 8'hA6;
    xfer(8'd133, 8, 8, 16'hFFFF, 1);
    chk(func_code == 2 && rx_word == 16'h00A6, "R2 R8 opt high read 133", rx_word, 16'h00A6);

    // abort in the middle of a read
    rd_byte = 8'h00; dc = done_cnt;
    @(negedge clk); m_id = 0; wait_h(H);
    for (int i = 0; i < 8; i++) begin
      m_ck = 0; m_d = 8'd133 >> i; wait_h(H); m_ck = 1; wait_h(H);
    end
    m_d = 1; m_id = 1; wait_h(H);
    for (int i = 0; i < 3; i++) begin m_ck = 0; wait_h(H); m_ck = 1; wait_h(H); end
    chk(data_pull == 1, "R7 pull before abort", data_pull, 1);
    rst_n = 0; #1;
    chk(data_pull == 0 && func_code == 0 && rx_word == 0, "R1 abort releases line", data_pull, 0);
    wait_h(3); m_id = 0; wait_h(H); m_id = 1; wait_h(2);
    rst_n = 1; wait_h(4 * H);
    chk(done_cnt == dc, "R1 aborted frame no strobe", done_cnt - dc, 0);

    opt_hi = 0;
    xfer(8'd128, 8, 16, 16'h7E81, 1);
    chk(rx_word == 16'h7E81, "R10 recovery after abort", rx_word, 16'h7E81);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule